// File: doc/BRIEF.md
# Debug Port Transaction Arbiter

This block sits behind a serial debug link that has already been unlocked. For every decoded debug-port transaction it picks the acknowledge code and the read data. It also feeds a narrow system-side request channel. Reads of the debug port's own registers are answered in the same transaction. Reads of the access port are posted: an accepted access-port read hands back the value that the previous access-port read captured, and it launches a new system-side read whose result waits for the next access-port read or for a read of the read-buffer register.

Writes to the debug port or the access port are accepted into a small in-order write buffer, so the host can move on while earlier work is still outstanding. A buffered write becomes visible to the system side only after a fixed settling delay, which stands in for the crossing into the slower system clock domain. When the buffer is full the block answers WAIT. Three accesses are exempt and are always accepted: the identification read, the status read and the abort write. A WAIT leaves every piece of state as it was, so the host can repeat the identical request. An abort empties the write buffer and discards any posted read result.

Top module: `dbg_txn_arbiter`

## Requirements
- R1: A debug-port read of address 0 is answered OK with the `IDCODE_VAL` parameter as data. It is accepted even when the write buffer is full.
- R2: A debug-port read of address 1 is answered OK with a status word whose bit 6 holds the current READOK flag and whose other bits are zero. It is accepted even when the write buffer is full. A debug-port read of address 2 returns zero.
- R3: An accepted access-port read answers OK with the result captured by the previous access-port read (zero after reset or abort) and launches one system-side read. It answers WAIT while an earlier system read is still in flight or while the write buffer holds any entry.
- R4: A debug-port read of address 3 (read buffer) answers OK with the most recently captured access-port result and launches nothing. It answers WAIT while a system read is in flight.
- R5: READOK is zero after reset. It is rewritten on every accepted access-port read and every accepted read-buffer read with the success flag (`sys_err` low at capture) of the result being returned. It holds its value at all other times.
- R6: Debug-port writes to addresses 1 to 3 and all access-port writes are answered OK and queued in a `WB_DEPTH`-entry buffer. They drain in order as system writes carrying the address, the port flag (`sys_ap`, 1 = access port) and the data. Any non-exempt access answers WAIT while the buffer is full.
- R7: A write that reaches the head of the buffer is offered on `sys_valid` no earlier than `SETTLE_CYC` clock edges after it reached the head. A pending system read takes the channel before buffered writes. An offered request holds its value until `sys_ready`.
- R8: A request answered WAIT changes no state. It queues nothing, launches nothing and leaves READOK unchanged.
- R9: A debug-port write of address 0 (abort) is always answered OK. It empties the write buffer and cancels any in-flight system read. It clears the pending result to zero with a failed flag, so `sys_valid` is low in the cycle after it.
- R10: Every request with `req_valid` high gets exactly one response, with `rsp_valid` high in the following cycle. The acknowledge code is 3'b001 for OK and 3'b010 for WAIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle pulse carrying a decoded transaction |
| req_ap | input | 1 | 1 = access port, 0 = debug port |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address bits |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_ack | output | 3 | Acknowledge code (001 OK, 010 WAIT) |
| rsp_rdata | output | 32 | Read data (zero for writes and WAIT) |
| rsp_readok | output | 1 | READOK status flag |
| sys_valid | output | 1 | System-side request valid |
| sys_write | output | 1 | System request is a write |
| sys_ap | output | 1 | System request targets the access port |
| sys_addr | output | 2 | System request address |
| sys_wdata | output | 32 | System write data |
| sys_ready | input | 1 | System side accepts/completes the request |
| sys_rdata | input | 32 | Read data, valid with the completing handshake |
| sys_err | input | 1 | Read failed, valid with the completing handshake |

## Verification
The bench builds the block with its defaults: a two-entry write buffer, a two-edge settling delay and a fixed identification value. The shallow buffer lets two writes reach the full state while the system side is held off, and that exposes the WAIT path alongside the three exempt accesses. The short delay makes the exact edge at which a write first appears on the system channel observable. Holding `sys_ready` low also keeps a posted read in flight, so both the busy WAIT and the abort that cancels it can be driven.

// File: rtl/dbgarb_pkg.sv
package dbgarb_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 2;
  localparam int READOK_BIT = 6;

  localparam logic [2:0] ACK_OK   = 3'b001;
  localparam logic [2:0] ACK_WAIT = 3'b010;

  typedef struct packed {
    logic              ap;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wb_entry_t;
endpackage

// File: rtl/dbgarb_wbuf.sv
module dbgarb_wbuf
  import dbgarb_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int SETTLE = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  wb_entry_t push_entry,
  input  logic      pop,
  input  logic      flush,
  output wb_entry_t head,
  output logic      head_vis,
  output logic      full,
  output logic      empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(SETTLE + 2);

  logic [PW-1:0] wr_ptr_q, wr_ptr_nx, rd_ptr_q, rd_ptr_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [SW-1:0] settle_q, settle_nx;
  wb_entry_t     slot_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    wb_entry_t slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot_q <= '0;
      else if (push && (wr_ptr_q == PW'(g)))   slot_q <= push_entry;
    end
    assign slot_w[g] = slot_q;
  end

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign head     = slot_w[rd_ptr_q];
  assign head_vis = !empty && (settle_q == '0);

  always_comb begin
    wr_ptr_nx = wr_ptr_q;
    rd_ptr_nx = rd_ptr_q;
    cnt_nx    = cnt_q;
    settle_nx = settle_q;
    if (flush) begin
      wr_ptr_nx = '0;
      rd_ptr_nx = '0;
      cnt_nx    = '0;
      settle_nx = '0;
    end else begin
      if (push) wr_ptr_nx = bump(wr_ptr_q);
      if (pop)  rd_ptr_nx = bump(rd_ptr_q);
      case ({push, pop})
        2'b10:   cnt_nx = cnt_q + 1'b1;
        2'b01:   cnt_nx = cnt_q - 1'b1;
        default: cnt_nx = cnt_q;
      endcase
      if (pop || (push && empty)) settle_nx = SW'(SETTLE);
      else if (settle_q != '0)    settle_nx = settle_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      settle_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_nx;
      rd_ptr_q <= rd_ptr_nx;
      cnt_q    <= cnt_nx;
      settle_q <= settle_nx;
    end
  end
endmodule

// File: rtl/dbgarb_rdpost.sv
module dbgarb_rdpost
  import dbgarb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] launch_addr,
  input  logic              cancel,
  input  logic              done,
  input  logic [DATA_W-1:0] done_data,
  input  logic              done_err,
  output logic              busy,
  output logic [ADDR_W-1:0] busy_addr,
  output logic [DATA_W-1:0] res_data,
  output logic              res_ok
);
  logic              busy_nx, ok_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic [DATA_W-1:0] data_nx;

  always_comb begin
    busy_nx = busy;
    addr_nx = busy_addr;
    data_nx = res_data;
    ok_nx   = res_ok;
    if (cancel) begin
      busy_nx = 1'b0;
      data_nx = '0;
      ok_nx   = 1'b0;
    end else if (launch) begin
      busy_nx = 1'b1;
      addr_nx = launch_addr;
    end else if (done) begin
      busy_nx = 1'b0;
      data_nx = done_data;
      ok_nx   = !done_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      busy_addr <= '0;
      res_data  <= '0;
      res_ok    <= 1'b0;
    end else begin
      busy      <= busy_nx;
      busy_addr <= addr_nx;
      res_data  <= data_nx;
      res_ok    <= ok_nx;
    end
  end
endmodule

// File: rtl/dbgarb_ackgen.sv
module dbgarb_ackgen
  import dbgarb_pkg::*;
#(
  parameter logic [DATA_W-1:0] IDCODE_VAL = 32'h3A51_0D17
) (
  input  logic              req_valid,
  input  logic              req_ap,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              wb_full,
  input  logic              wb_empty,
  input  logic              rd_busy,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_ok,
  input  logic              readok,
  output logic [2:0]        ack,
  output logic [DATA_W-1:0] rdata,
  output logic              push,
  output logic              launch,
  output logic              abort,
  output logic              readok_upd,
  output logic              readok_val
);
  logic is_abort, is_id, is_stat, is_rdbuf, is_apread, exempt, stall, ok;

  always_comb begin
    is_abort  = !req_ap && req_write  && (req_addr == 2'd0);
    is_id     = !req_ap && !req_write && (req_addr == 2'd0);
    is_stat   = !req_ap && !req_write && (req_addr == 2'd1);
    is_rdbuf  = !req_ap && !req_write && (req_addr == 2'd3);
    is_apread = req_ap && !req_write;
    exempt    = is_abort || is_id || is_stat;
    stall     = !exempt && (wb_full
                || (is_apread && (rd_busy || !wb_empty))
                || (is_rdbuf && rd_busy));
    ok        = req_valid && !stall;

    ack   = stall ? ACK_WAIT : ACK_OK;
    rdata = '0;
    if (ok) begin
      if (is_id)                       rdata = IDCODE_VAL;
      else if (is_stat)                rdata[READOK_BIT] = readok;
      else if (is_apread || is_rdbuf)  rdata = res_data;
    end

    push       = ok && req_write && !is_abort;
    launch     = ok && is_apread;
    abort      = ok && is_abort;
    readok_upd = ok && (is_apread || is_rdbuf);
    readok_val = res_ok;
  end
endmodule

// File: rtl/dbg_txn_arbiter.sv
module dbg_txn_arbiter
  import dbgarb_pkg::*;
#(
  parameter int                WB_DEPTH   = 2,
  parameter int                SETTLE_CYC = 2,
  parameter logic [DATA_W-1:0] IDCODE_VAL = 32'h3A51_0D17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_ap,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [2:0]        rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_readok,
  output logic              sys_valid,
  output logic              sys_write,
  output logic              sys_ap,
  output logic [ADDR_W-1:0] sys_addr,
  output logic [DATA_W-1:0] sys_wdata,
  input  logic              sys_ready,
  input  logic [DATA_W-1:0] sys_rdata,
  input  logic              sys_err
);
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  wb_entry_t         wb_head;
  logic              wb_vis, wb_full, wb_empty, wb_pop;
  logic              rd_busy, rd_done, res_ok;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] res_data, ag_rdata;
  logic [2:0]        ag_ack;
  logic              ag_push, ag_launch, ag_abort, ag_rok_upd, ag_rok_val;

  dbgarb_ackgen #(.IDCODE_VAL(IDCODE_VAL)) u_ackgen (
    .req_valid (req_valid),
    .req_ap    (req_ap),
    .req_write (req_write),
    .req_addr  (req_addr),
    .wb_full   (wb_full),
    .wb_empty  (wb_empty),
    .rd_busy   (rd_busy),
    .res_data  (res_data),
    .res_ok    (res_ok),
    .readok    (rsp_readok),
    .ack       (ag_ack),
    .rdata     (ag_rdata),
    .push      (ag_push),
    .launch    (ag_launch),
    .abort     (ag_abort),
    .readok_upd(ag_rok_upd),
    .readok_val(ag_rok_val)
  );

  dbgarb_wbuf #(.DEPTH(WB_DEPTH), .SETTLE(SETTLE_CYC)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_sync),
    .push      (ag_push),
    .push_entry('{ap: req_ap, addr: req_addr, data: req_wdata}),
    .pop       (wb_pop),
    .flush     (ag_abort),
    .head      (wb_head),
    .head_vis  (wb_vis),
    .full      (wb_full),
    .empty     (wb_empty)
  );

  dbgarb_rdpost u_rdpost (
    .clk        (clk),
    .rst_n      (rst_sync),
    .launch     (ag_launch),
    .launch_addr(req_addr),
    .cancel     (ag_abort),
    .done       (rd_done),
    .done_data  (sys_rdata),
    .done_err   (sys_err),
    .busy       (rd_busy),
    .busy_addr  (rd_addr),
    .res_data   (res_data),
    .res_ok     (res_ok)
  );

  // A pending read owns the channel; buffered writes wait behind it.
  always_comb begin
    sys_valid = rd_busy || wb_vis;
    sys_write = !rd_busy;
    sys_ap    = rd_busy ? 1'b1 : wb_head.ap;
    sys_addr  = rd_busy ? rd_addr : wb_head.addr;
    sys_wdata = rd_busy ? '0 : wb_head.data;
    rd_done   = rd_busy && sys_ready;
    wb_pop    = !rd_busy && wb_vis && sys_ready;
  end

  logic              rsp_valid_nx, readok_nx;
  logic [2:0]        rsp_ack_nx;
  logic [DATA_W-1:0] rsp_rdata_nx;

  always_comb begin
    rsp_valid_nx = req_valid;
    rsp_ack_nx   = req_valid ? ag_ack : '0;
    rsp_rdata_nx = req_valid ? ag_rdata : '0;
    readok_nx    = ag_rok_upd ? ag_rok_val : rsp_readok;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      rsp_valid  <= 1'b0;
      rsp_ack    <= '0;
      rsp_rdata  <= '0;
      rsp_readok <= 1'b0;
    end else begin
      rsp_valid  <= rsp_valid_nx;
      rsp_ack    <= rsp_ack_nx;
      rsp_rdata  <= rsp_rdata_nx;
      rsp_readok <= readok_nx;
    end
  end
endmodule

// File: rtl/dbgarb_checker.sv
module dbgarb_checker #(
  parameter logic [31:0] IDCODE_VAL = 32'h3A51_0D17
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ap,
  input logic        req_write,
  input logic [1:0]  req_addr,
  input logic        rsp_valid,
  input logic [2:0]  rsp_ack,
  input logic [31:0] rsp_rdata,
  input logic        rsp_readok,
  input logic        sys_valid,
  input logic        sys_write,
  input logic        sys_ap,
  input logic [1:0]  sys_addr,
  input logic [31:0] sys_wdata,
  input logic        sys_ready
);
  logic abort_req;
  assign abort_req = req_valid && !req_ap && req_write && (req_addr == 2'd0);

  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r10_ack_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ack == 3'b001 || rsp_ack == 3'b010));
  a_r1_idcode: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ap && !req_write && req_addr == 2'd0)
      |=> (rsp_ack == 3'b001 && rsp_rdata == IDCODE_VAL));
  a_r9_abort_ok: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (rsp_ack == 3'b001 && !sys_valid));
  a_r5_readok_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_readok));
  a_r7_sys_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_valid && !sys_ready && !abort_req)
      |=> (sys_valid && $stable(sys_write) && $stable(sys_ap)
           && $stable(sys_addr) && $stable(sys_wdata)));
endmodule

bind dbg_txn_arbiter dbgarb_checker #(.IDCODE_VAL(IDCODE_VAL)) u_dbgarb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ap    (req_ap),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ack   (rsp_ack),
  .rsp_rdata (rsp_rdata),
  .rsp_readok(rsp_readok),
  .sys_valid (sys_valid),
  .sys_write (sys_write),
  .sys_ap    (sys_ap),
  .sys_addr  (sys_addr),
  .sys_wdata (sys_wdata),
  .sys_ready (sys_ready)
);

// File: tb/dbg_txn_arbiter_bench.sv
`timescale 1ns/1ps
module dbg_txn_arbiter_bench;
  localparam logic [31:0] IDC  = 32'h3A51_0D17;
  localparam logic [2:0]  OK   = 3'b001;
  localparam logic [2:0]  WT   = 3'b010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ap = 1'b0, req_write = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_readok;
  logic [2:0]  rsp_ack;
  logic [31:0] rsp_rdata;
  logic        sys_valid, sys_write, sys_ap;
  logic [1:0]  sys_addr;
  logic [31:0] sys_wdata;
  logic        sys_ready = 1'b1;
  logic [31:0] sys_rdata = '0;
  logic        sys_err = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  logic [34:0] last_wr = '0;

  always #4 clk = ~clk;

  dbg_txn_arbiter u_dbg_txn_arbiter (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ap(req_ap), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .rsp_readok(rsp_readok),
    .sys_valid(sys_valid), .sys_write(sys_write), .sys_ap(sys_ap),
    .sys_addr(sys_addr), .sys_wdata(sys_wdata),
    .sys_ready(sys_ready), .sys_rdata(sys_rdata), .sys_err(sys_err)
  );

  always @(posedge clk) begin
    if (sys_valid && sys_ready && sys_write) begin
      wr_cnt  <= wr_cnt + 1;
      last_wr <= {sys_ap, sys_addr, sys_wdata};
    end
  end

  typedef struct packed {
    logic        ap;
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] sdata;
    logic        serr;
    logic [2:0]  ack;
    logic [31:0] rdata;
    logic        rok;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd0, 32'h0,         32'h0,         1'b0, 3'b001, 32'h3A51_0D17, 1'b0},
    '{1'b1, 1'b0, 2'd1, 32'h0,         32'h1111_1111, 1'b0, 3'b001, 32'h0,         1'b0},
    '{1'b1, 1'b0, 2'd2, 32'h0,         32'h2222_2222, 1'b0, 3'b001, 32'h1111_1111, 1'b1},
    '{1'b0, 1'b0, 2'd3, 32'h0,         32'h0,         1'b0, 3'b001, 32'h2222_2222, 1'b1},
    '{1'b1, 1'b0, 2'd0, 32'h0,         32'h3333_3333, 1'b1, 3'b001, 32'h2222_2222, 1'b1},
    '{1'b0, 1'b0, 2'd3, 32'h0,         32'h0,         1'b0, 3'b001, 32'h3333_3333, 1'b0},
    '{1'b0, 1'b0, 2'd1, 32'h0,         32'h0,         1'b0, 3'b001, 32'h0,         1'b0},
    '{1'b1, 1'b0, 2'd3, 32'h0,         32'h4444_4444, 1'b0, 3'b001, 32'h3333_3333, 1'b0},
    '{1'b0, 1'b0, 2'd3, 32'h0,         32'h0,         1'b0, 3'b001, 32'h4444_4444, 1'b1},
    '{1'b0, 1'b0, 2'd1, 32'h0,         32'h0,         1'b0, 3'b001, 32'h0000_0040, 1'b1},
    '{1'b0, 1'b0, 2'd2, 32'h0,         32'h0,         1'b0, 3'b001, 32'h0,         1'b1},
    '{1'b0, 1'b1, 2'd2, 32'hCAFE_0002, 32'h0,         1'b0, 3'b001, 32'h0,         1'b1},
    '{1'b1, 1'b1, 2'd1, 32'hBEEF_0001, 32'h0,         1'b0, 3'b001, 32'h0,         1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic [34:0] act, input logic [34:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic ap, input logic wr,
                       input logic [1:0] addr, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_ap = ap; req_write = wr;
    req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R10 R5: reset state
    chk("R10", "rsp_valid after reset", rsp_valid, 0);
    chk("R5", "readok after reset", rsp_readok, 0);
    chk("R7", "sys_valid after reset", sys_valid, 0);

    // Table walk: R1 R2 R3 R4 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      sys_rdata = VECS[i].sdata;
      sys_err   = VECS[i].serr;
      issue(VECS[i].ap, VECS[i].wr, VECS[i].addr, VECS[i].wdata);
      chk("R10", $sformatf("vec%0d rsp_valid", i), rsp_valid, 1);
      chk("R3/R4", $sformatf("vec%0d ack", i), rsp_ack, VECS[i].ack);
      chk("R1/R2", $sformatf("vec%0d rdata", i), rsp_rdata, VECS[i].rdata);
      chk("R5", $sformatf("vec%0d readok", i), rsp_readok, VECS[i].rok);
      idle(6);
    end
    sys_err = 1'b0;
    chk("R6", "drained write count", wr_cnt, 2);
    chk("R6", "last drained write", last_wr, {1'b1, 2'd1, 32'hBEEF_0001});

    // R7: settling delay before a write is offered
    issue(1'b1, 1'b1, 2'd2, 32'h5E77_0007);
    chk("R7", "sys_valid one edge after accept", sys_valid, 0);
    @(negedge clk);
    chk("R7", "sys_valid two edges after accept", sys_valid, 0);
    @(negedge clk);
    chk("R7", "sys_valid at settle", sys_valid, 1);
    chk("R7", "offered write", {sys_write, sys_ap, sys_addr, sys_wdata},
        {1'b1, 1'b1, 2'd2, 32'h5E77_0007});
    idle(4);

    // R6 R8 R1 R2 R3 R4: full buffer
    base = wr_cnt;
    sys_ready = 1'b0;
    issue(1'b1, 1'b1, 2'd0, 32'hA100_0001);
    chk("R6", "first buffered write", rsp_ack, OK);
    issue(1'b0, 1'b1, 2'd3, 32'hA200_0002);
    chk("R6", "second buffered write", rsp_ack, OK);
    issue(1'b1, 1'b1, 2'd1, 32'hA300_0003);
    chk("R6", "write into full buffer", rsp_ack, WT);
    issue(1'b0, 1'b0, 2'd0, 32'h0);
    chk("R1", "idcode when full ack", rsp_ack, OK);
    chk("R1", "idcode when full data", rsp_rdata, IDC);
    issue(1'b0, 1'b0, 2'd1, 32'h0);
    chk("R2", "status when full ack", rsp_ack, OK);
    chk("R2", "status when full data", rsp_rdata, 32'h40);
    issue(1'b0, 1'b0, 2'd3, 32'h0);
    chk("R6", "read buffer when full", rsp_ack, WT);
    issue(1'b1, 1'b0, 2'd1, 32'h0);
    chk("R3", "ap read with writes queued", rsp_ack, WT);
    chk("R8", "readok after waits", rsp_readok, 1);
    sys_ready = 1'b1;
    idle(12);
    chk("R8", "waited write not queued", wr_cnt - base, 2);
    chk("R6", "in-order drain last", last_wr, {1'b0, 2'd3, 32'hA200_0002});

    // R9: abort flushes the buffer
    base = wr_cnt;
    sys_ready = 1'b0;
    issue(1'b1, 1'b1, 2'd0, 32'hB100_0001);
    issue(1'b1, 1'b1, 2'd1, 32'hB200_0002);
    issue(1'b0, 1'b1, 2'd0, 32'h0000_001E);
    chk("R9", "abort when full ack", rsp_ack, OK);
    chk("R9", "sys_valid after abort", sys_valid, 0);
    sys_ready = 1'b1;
    idle(10);
    chk("R9", "flushed writes not drained", wr_cnt - base, 0);

    // R3 R4: read in flight
    sys_ready = 1'b0;
    sys_rdata = 32'h5555_5555;
    issue(1'b1, 1'b0, 2'd1, 32'h0);
    chk("R3", "ap read after abort ack", rsp_ack, OK);
    chk("R3", "ap read after abort data", rsp_rdata, 32'h0);
    issue(1'b1, 1'b0, 2'd2, 32'h0);
    chk("R3", "ap read while busy", rsp_ack, WT);
    issue(1'b0, 1'b0, 2'd3, 32'h0);
    chk("R4", "read buffer while busy", rsp_ack, WT);
    chk("R7", "read offered on channel", {sys_valid, sys_write, sys_ap, sys_addr},
        {1'b1, 1'b0, 1'b1, 2'd1});
    sys_ready = 1'b1;
    idle(3);
    issue(1'b0, 1'b0, 2'd3, 32'h0);
    chk("R4", "read buffer after capture ack", rsp_ack, OK);
    chk("R4", "read buffer after capture data", rsp_rdata, 32'h5555_5555);
    chk("R5", "readok after capture", rsp_readok, 1);

    // R9: abort cancels an in-flight read
    sys_ready = 1'b0;
    sys_rdata = 32'h6666_6666;
    issue(1'b1, 1'b0, 2'd0, 32'h0);
    chk("R3", "ap read returns previous", rsp_rdata, 32'h5555_5555);
    issue(1'b0, 1'b1, 2'd0, 32'h0);
    chk("R9", "abort with read in flight", sys_valid, 0);
    sys_ready = 1'b1;
    idle(4);
    issue(1'b0, 1'b0, 2'd3, 32'h0);
    chk("R9", "result cleared data", rsp_rdata, 32'h0);
    chk("R9", "result cleared readok", rsp_readok, 0);
    idle(2);
    chk("R10", "no response when idle", rsp_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule